// File: doc/BRIEF.md
# Carry-Save Shift-Add Multiplier with Approximate Final Adder

This block multiplies two unsigned W-bit operands into a 2W-bit product. It works in three phases. First it builds one partial-product row per multiplier bit, writing a left-shifted copy of the multiplicand only where that bit is 1. Then it folds the rows with one row of independent 3:2 carry-save cells per cycle until a sum word and a carry word remain. Last, a bit-serial adder walks those two words from the least significant position upward.

The final adder has two modes. In exact mode every position takes two cycles: one forms the sum bit, the next moves the carry. In approximate mode the lowest K positions each take one cycle. Such a position keeps its carry-out exact but writes the inverse of that carry as its sum bit, which is wrong only when all three inputs agree. Positions at or above K stay exact, so the error is confined to the low part of the product and the latency drops by K cycles. A start/done handshake sequences the operation, and a counter shows how many cycles the last operation took.

Top module: `csa_shift_mult`

## Requirements
- R1: After a synchronous active-low reset, `product`, `cycles`, `done` and `busy` are all zero.
- R2: `start` is taken only when `busy` is low. The operands and mode are captured on that edge and `busy` rises in the next cycle. A `start`, or a change of operands, while `busy` is high (including the `done` cycle) has no effect on the result or the timing.
- R3: With `mode_approx` = 0, `product` equals op_a × op_b for every operand pair. The same holds with `mode_approx` = 1 when K = 0.
- R4: Partial-product row i holds op_a shifted left by i when op_b bit i is 1. Otherwise the row is never written and stays zero.
- R5: Reduction is a series of 3:2 steps, one per cycle. The first step combines rows 0, 1 and 2, and each later step combines the running sum word, the running carry word and the next row in ascending order. A step's carry word is the per-bit majority shifted left by one, truncated to 2W bits. Every step preserves the arithmetic total modulo 2^(2W).
- R6: In the final add, with `mode_approx` = 1, each position p < K outputs the inverse of its exact carry-out, and the carry passed upward stays exact. Positions p ≥ K, and all positions when `mode_approx` = 0, output the exact sum bit.
- R7: An operation takes W + (W − 2) + 4W − A cycles from the accepting edge to the edge that raises `done`, where A is K in approximate mode and 0 in exact mode. `cycles` restarts at 0 on acceptance and shows this value while `done` is high.
- R8: `done` is high for exactly one cycle, the cycle after the last add step. `busy` stays high from the cycle after acceptance up to and including that cycle, then falls.
- R9: Once `done` has been high, `product` and `cycles` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; sampled only while idle |
| mode_approx | input | 1 | 1 selects approximate handling of the low K result bits |
| op_a | input | W | Multiplicand, unsigned |
| op_b | input | W | Multiplier, unsigned |
| product | output | 2W | Result; final once `done` is high |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while an operation is in progress, including the `done` cycle |
| cycles | output | CNT_W | Cycle count of the current or most recent operation |

## Verification
Two events can fall in the same cycle: a new `start` and the `done` pulse that ends the previous operation. The bench provokes this by raising `start` with fresh operands exactly in the cycle where `done` is high. It then judges that the request was dropped: `busy` must stay low afterwards, `product` and `cycles` must keep the old results, and the per-cycle reference must show no new operation. A second case raises `start` with changed operands in the middle of the reduction phase, and the final product must still belong to the captured operands.

// File: rtl/mulcs_pkg.sv
`timescale 1ns/1ps
// Package: shared control encoding for the carry-save shift-add multiplier.
// Assumes a single sequencer walks the phases in declaration order.
package mulcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PP,
        ST_RED,
        ST_ADD,
        ST_DONE
    } mul_state_t;
endpackage

// File: rtl/mulcs_ppgen.sv
`timescale 1ns/1ps
// Module: partial-product row store.
// Writes row idx with the shifted multiplicand only when the multiplier bit
// is 1; zero bits leave the row untouched (cleared at operation start).
// Assumes clr and wr are never high together.
module mulcs_ppgen #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [IW-1:0]           idx,
    input  logic                    mbit,
    input  logic [W-1:0]            mcand,
    output logic [W-1:0][2*W-1:0]   rows
);
    localparam int W2 = 2 * W;

    // Row storage: clear on new operation, write only for set multiplier bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rows <= '0;
        end else if (wr && mbit) begin
            rows[idx] <= {{W{1'b0}}, mcand} << idx;
        end
    end

    AST_ZERO_ROW_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mbit) |=> (rows[$past(idx)] == {W2{1'b0}})); // R4
endmodule

// File: rtl/mulcs_csa.sv
`timescale 1ns/1ps
// Module: one row of independent 3:2 carry-save cells.
// No carry ripples between cells; the carry word is the per-bit majority
// shifted left by one, the top carry being dropped (product fits in N bits).
module mulcs_csa #(
    parameter int N = 16
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic [N-1:0] z,
    output logic [N-1:0] s,
    output logic [N-1:0] c
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        // Sum bit of cell i.
        assign s[i] = x[i] ^ y[i] ^ z[i];
        if (i == 0) begin : g_lsb
            assign c[0] = 1'b0;
        end else begin : g_up
            // Carry of cell i-1 lands one position higher.
            assign c[i] = (x[i-1] & y[i-1]) | (x[i-1] & z[i-1]) | (y[i-1] & z[i-1]);
        end
    end
endmodule

// File: rtl/mulcs_serial_add.sv
`timescale 1ns/1ps
// Module: bit-serial final adder, LSB first.
// Exact position: two cycles (sum bit, then carry move).
// Approximate position (approx=1 and position < K): one cycle, sum bit is
// the inverse of the exact carry-out. Assumes x and y are stable while run.
module mulcs_serial_add #(
    parameter int W2 = 16,
    parameter int K  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          run,
    input  logic          approx,
    input  logic [W2-1:0] x,
    input  logic [W2-1:0] y,
    output logic [W2-1:0] result,
    output logic          last
);
    localparam int PW = (W2 > 1) ? $clog2(W2) : 1;
    localparam logic [PW-1:0] LAST_POS = PW'(W2 - 1);
    localparam logic [PW:0]   K_LIM    = (PW+1)'(K);

    logic [PW-1:0] pos;
    logic          cy;
    logic          half;
    logic          xa, ya, cout, ap_bit;

    // Per-position carry-out and mode decision.
    always_comb begin
        xa     = x[pos];
        ya     = y[pos];
        cout   = (xa & ya) | (xa & cy) | (ya & cy);
        ap_bit = approx && ({1'b0, pos} < K_LIM);
    end

    assign last = run && (pos == LAST_POS) && (ap_bit || half);

    // Serial step: position pointer, carry and result bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            cy     <= 1'b0;
            half   <= 1'b0;
            result <= '0;
        end else if (init) begin
            pos  <= '0;
            cy   <= 1'b0;
            half <= 1'b0;
        end else if (run) begin
            if (ap_bit) begin
                result[pos] <= ~cout;
                cy          <= cout;
                pos         <= pos + 1'b1;
            end else if (!half) begin
                result[pos] <= xa ^ ya ^ cy;
                half        <= 1'b1;
            end else begin
                cy   <= cout;
                half <= 1'b0;
                pos  <= pos + 1'b1;
            end
        end
    end

    AST_EXACT_TWO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !init && !ap_bit && !half) |=> (half && $stable(pos))); // R7
    AST_APPROX_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !init && ap_bit) |=> (result[$past(pos)] == ~cy)); // R6
endmodule

// File: rtl/csa_shift_mult.sv
`timescale 1ns/1ps
// Module: top of the sequential carry-save shift-add multiplier.
// Sequencer: capture operands, W cycles of row generation, W-2 cycles of
// 3:2 folding, then a serial final add; done pulses one cycle at the end.
// Assumes W >= 3 and K <= 2*W.
module csa_shift_mult
    import mulcs_pkg::*;
#(
    parameter int W     = 8,
    parameter int K     = 6,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode_approx,
    input  logic [W-1:0]       op_a,
    input  logic [W-1:0]       op_b,
    output logic [2*W-1:0]     product,
    output logic               done,
    output logic               busy,
    output logic [CNT_W-1:0]   cycles
);
    localparam int W2 = 2 * W;
    localparam int IW = $clog2(W);
    localparam logic [IW-1:0] LAST_ROW  = IW'(W - 1);
    localparam logic [IW-1:0] FIRST_RED = IW'(2);

    mul_state_t           state;
    logic [W-1:0]         a_q, b_q;
    logic                 approx_q;
    logic [IW-1:0]        idx;
    logic [W-1:0][W2-1:0] rows;
    logic [W2-1:0]        s_q, c_q;
    logic [W2-1:0]        x_op, y_op, z_op, csa_s, csa_c;
    logic                 accept, add_last;

    assign accept = (state == ST_IDLE) && start;
    assign done   = (state == ST_DONE);
    assign busy   = (state != ST_IDLE);

    mulcs_ppgen #(.W(W), .IW(IW)) u_pp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .wr    (state == ST_PP),
        .idx   (idx),
        .mbit  (b_q[idx]),
        .mcand (a_q),
        .rows  (rows)
    );

    // Operand selection for the 3:2 row: first step reads rows 0 and 1.
    always_comb begin
        x_op = (idx == FIRST_RED) ? rows[0] : s_q;
        y_op = (idx == FIRST_RED) ? rows[1] : c_q;
        z_op = rows[idx];
    end

    mulcs_csa #(.N(W2)) u_csa (
        .x (x_op),
        .y (y_op),
        .z (z_op),
        .s (csa_s),
        .c (csa_c)
    );

    mulcs_serial_add #(.W2(W2), .K(K)) u_add (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (accept),
        .run    (state == ST_ADD),
        .approx (approx_q),
        .x      (s_q),
        .y      (c_q),
        .result (product),
        .last   (add_last)
    );

    // Phase sequencer, operand capture and reduction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            a_q      <= '0;
            b_q      <= '0;
            approx_q <= 1'b0;
            idx      <= '0;
            s_q      <= '0;
            c_q      <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    a_q      <= op_a;
                    b_q      <= op_b;
                    approx_q <= mode_approx;
                    idx      <= '0;
                    state    <= ST_PP;
                end
                ST_PP: begin
                    if (idx == LAST_ROW) begin
                        idx   <= FIRST_RED;
                        state <= ST_RED;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_RED: begin
                    s_q <= csa_s;
                    c_q <= csa_c;
                    if (idx == LAST_ROW) state <= ST_ADD;
                    else                 idx   <= idx + 1'b1;
                end
                ST_ADD:  if (add_last) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Latency counter: restarts on acceptance, counts working cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            cycles <= '0;
        end else if (state == ST_PP || state == ST_RED || state == ST_ADD) begin
            cycles <= cycles + 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R8
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(product) && $stable(cycles))); // R9
    AST_CSA_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RED) |-> (W2'(csa_s + csa_c) == W2'(x_op + y_op + z_op))); // R5
endmodule

// File: tb/sim_csa_shift_mult.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference compared with the multiplier.
module sim_csa_shift_mult;
    localparam int W     = 8;
    localparam int K     = 6;
    localparam int CNT_W = 16;
    localparam int W2    = 2 * W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode_approx = 1'b0;
    logic [W-1:0]      op_a = '0;
    logic [W-1:0]      op_b = '0;
    logic [W2-1:0]     product;
    logic              done;
    logic              busy;
    logic [CNT_W-1:0]  cycles;

    int n_chk = 0;
    int n_err = 0;
    int wd    = 0;
    bit wd_hit = 1'b0;

    // Reference model state: 0 idle, 1 working, 2 done cycle.
    int            m_state = 0;
    int            m_left  = 0;
    int            m_cyc   = 0;
    logic [W2-1:0] m_prod  = '0;
    logic [W2-1:0] m_pend  = '0;

    always #2.5 clk = ~clk;

    csa_shift_mult #(.W(W), .K(K), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_approx(mode_approx),
        .op_a(op_a), .op_b(op_b), .product(product), .done(done),
        .busy(busy), .cycles(cycles)
    );

    function automatic int lat_of(input logic m);
        return W + (W - 2) + 4 * W - (m ? K : 0);
    endfunction

    // Expected result from R4, R5, R6.
    function automatic logic [W2-1:0] ref_prod(input logic [W-1:0] a,
                                               input logic [W-1:0] b,
                                               input logic m);
        logic [W2-1:0] rw [W];
        logic [W2-1:0] s, c, t, r;
        logic cy, co;
        for (int i = 0; i < W; i++) rw[i] = b[i] ? ({{W{1'b0}}, a} << i) : '0;
        s = rw[0];
        c = rw[1];
        for (int j = 2; j < W; j++) begin
            t = s ^ c ^ rw[j];
            c = ((s & c) | (s & rw[j]) | (c & rw[j])) << 1;
            s = t;
        end
        cy = 1'b0;
        r  = '0;
        for (int p = 0; p < W2; p++) begin
            co   = (s[p] & c[p]) | (s[p] & cy) | (c[p] & cy);
            r[p] = (m && p < K) ? ~co : (s[p] ^ c[p] ^ cy);
            cy   = co;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model advance on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_cyc = 0; m_prod = '0; m_pend = '0;
        end else begin
            case (m_state)
                0: if (start) begin
                    m_pend  = ref_prod(op_a, op_b, mode_approx);
                    m_left  = lat_of(mode_approx);
                    m_cyc   = 0;
                    m_state = 1;
                end
                1: begin
                    m_cyc++;
                    m_left--;
                    if (m_left == 0) begin
                        m_state = 2;
                        m_prod  = m_pend;
                    end
                end
                default: m_state = 0;
            endcase
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !wd_hit) begin
            chk(done == (m_state == 2), "R8 done", 64'(done), 64'(m_state == 2));
            chk(busy == (m_state != 0), "R8 busy", 64'(busy), 64'(m_state != 0));
            chk(cycles == CNT_W'(m_cyc), "R7 cycles", 64'(cycles), 64'(m_cyc));
            if (m_state != 1)
                chk(product == m_prod, "R9 product", 64'(product), 64'(m_prod));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !wd_hit) begin
            wd_hit = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic wait_done();
        for (int k = 0; k < 400 && m_state != 2; k++) @(negedge clk);
    endtask

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic m);
        logic [W2-1:0] full;
        full = W2'(a) * W2'(b);
        @(negedge clk);
        op_a = a; op_b = b; mode_approx = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        if (!m || K == 0)
            chk(product == full, "R3 exact product", 64'(product), 64'(full));
        else
            chk(product == ref_prod(a, b, 1'b1), "R6 approx product",
                64'(product), 64'(ref_prod(a, b, 1'b1)));
        chk(cycles == CNT_W'(lat_of(m)), "R7 latency", 64'(cycles), 64'(lat_of(m)));
        @(negedge clk);
    endtask

    initial begin
        logic [W2-1:0] keep;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(product == '0, "R1 product", 64'(product), 0);
        chk(done == 1'b0, "R1 done", 64'(done), 0);
        chk(busy == 1'b0, "R1 busy", 64'(busy), 0);
        chk(cycles == '0, "R1 cycles", 64'(cycles), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4: corners in exact mode.
        run_op(8'h00, 8'hA5, 1'b0);
        run_op(8'hA5, 8'h00, 1'b0);  // R4: all rows skipped
        run_op(8'hFF, 8'hFF, 1'b0);
        run_op(8'h01, 8'h80, 1'b0);
        run_op(8'h5A, 8'h81, 1'b0);  // R4: mostly zero rows
        // R6 / R5: approximate mode on the same corners.
        run_op(8'hFF, 8'hFF, 1'b1);
        run_op(8'h00, 8'h00, 1'b1);
        run_op(8'h37, 8'hC9, 1'b1);
        for (int i = 0; i < 12; i++) begin
            run_op(W'($urandom), W'($urandom), 1'b0);
            run_op(W'($urandom), W'($urandom), 1'b1);
        end

        // R2: start with new operands during reduction is ignored.
        @(negedge clk);
        op_a = 8'hC3; op_b = 8'h3C; mode_approx = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (W + 2) @(negedge clk);
        op_a = 8'h11; op_b = 8'h22; mode_approx = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(product == 16'(16'hC3 * 16'h3C), "R2 busy start ignored",
            64'(product), 64'(16'hC3 * 16'h3C));

        // R2 / R9: start coinciding with the done pulse is dropped.
        keep = product;
        op_a = 8'h77; op_b = 8'h99; mode_approx = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R2 start in done cycle", 64'(busy), 0);
        repeat (5) @(negedge clk);
        chk(product == keep, "R9 product held", 64'(product), 64'(keep));
        chk(cycles == CNT_W'(lat_of(1'b0)), "R9 cycles held",
            64'(cycles), 64'(lat_of(1'b0)));

        // R2: back-to-back with start held high.
        @(negedge clk);
        op_a = 8'h0F; op_b = 8'hF0; mode_approx = 1'b1; start = 1'b1;
        wait_done();
        @(negedge clk);
        op_a = 8'hE1; op_b = 8'h1E; mode_approx = 1'b0;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(product == 16'(16'hE1 * 16'h1E), "R2 back-to-back",
            64'(product), 64'(16'hE1 * 16'h1E));
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule